// File: doc/BRIEF.md
# Windowed Address Translator

This block turns a 32-bit request address into a physical address and a granted byte count for a small processor memory system. The top address byte chooses the route. Three routes reach physical memory directly: unified, instruction and data memory. Two routes go through a windowed logical space, one for data and one for instructions. Each logical space is split into equal windows. A 16-bit map register for each window says where that window lands, according to a 2-bit space code and a segment field.

The map registers sit inside the block. They are written through a small register port that uses data-memory addresses. Each request gets a response one cycle later, or a fault. The granted length never lets an access run past a window, a segment or a test-wrap boundary.

One data window is special: it ignores its space code and maps into an I/O space. A nibble of its map register, picked by the offset, selects the I/O page. An instruction window with space code 11 runs in a test mode that wraps the offset into a small region at the bottom of instruction memory.

Top module: `addr_window_xlat`

## Requirements
- R1: The route is taken from request address bits [31:24]. Routes 0x00, 0x01 and 0x02 pass the address through unchanged as a physical unified, instruction or data address. Routes 0x10 (logical data) and 0x11 (logical instruction) are translated. Any other route faults.
- R2: On a physical route, the granted length is the requested length clamped so that the access ends at or before the next 64 KB segment boundary. A requested length of zero is granted as zero, with no fault.
- R3: A logical data offset (address bits [23:0]) at or above DWIN×DBLK (0x10000 by default) faults. Otherwise the window is the offset divided by DBLK and the in-window offset is the offset modulo DBLK.
- R4: Data map fields are the space code in bits [13:12] and the segment in bits [9:0]. Code 00 gives 0x00000000 + seg×DBLK + woff. Code 01 gives 0x01000000 + seg×DBLK + woff. Code 10 gives 0x02000000 + (seg<<16) + window×DBLK + woff.
- R5: Space code 11 in a data map register (other than the I/O window) faults.
- R6: Data window 3 ignores its space code. It maps to 0x02000000 + nib×0x10000 + 0xC000 + woff, where nib is nibble ((woff/0x1000) mod 4) of the map register, counted from the most significant nibble (index 0 = bits [15:12]).
- R7: Instruction map fields are the space code in bits [13:12] and the segment in bits [6:0]. Code 00 gives 0x00000000 + (seg<<17) + woff. Code 01 gives 0x01000000 + window×IBLK + woff.
- R8: Instruction space code 10 faults. Code 11 maps to 0x01000000 + (woff mod 0x800), and the length is clamped so the access does not pass 0x800.
- R9: A logical instruction offset at or above IWIN×IBLK (0x40000 by default) faults.
- R10: On a logical route, the granted length is clamped so the access does not cross the end of its window.
- R11: All map registers reset to zero. A write to 0xFF00+2i sets instruction map i. A write to 0xFF08+2i sets data map i. A write to 0xFF04 sets data map 2. Writes to any other address change nothing. A write is seen by requests from the next cycle on, not by a request in the same cycle.
- R12: A response (rsp_valid high) appears exactly one cycle after each request with req_valid high, and in no other cycle. A faulting response has a granted length of zero and an address of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Map register write strobe |
| cfg_addr | input | 16 | Map register write address (data-memory address) |
| cfg_wdata | input | 16 | Map register write value |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Request address; bits [31:24] are the route |
| req_len | input | LEN_W | Requested byte count |
| rsp_valid | output | 1 | Response present |
| rsp_addr | output | 32 | Physical address |
| rsp_len | output | LEN_W | Granted byte count |
| rsp_fault | output | 1 | Translation fault |

## Verification
The map registers cannot be read back, so every check of their state has to go through a translation. The hardest case to reach is a write and a request in the same cycle: the request must still see the old mapping. The bench drives that combined cycle directly and follows it with a second request that must see the new mapping. Writes to unused map addresses, including one next to the alias address, are followed by translations through every window those writes could have disturbed. The I/O window is reached at all four nibble positions. Its top page is also used to test the window-end clamp.

// File: rtl/awx_pkg.sv
`timescale 1ns/1ps
package awx_pkg;

  typedef enum logic [1:0] {
    SP_UNIF = 2'b00,
    SP_INSN = 2'b01,
    SP_DATA = 2'b10,
    SP_ALT  = 2'b11
  } space_e;

  localparam logic [7:0] RT_UNIF  = 8'h00;
  localparam logic [7:0] RT_INSN  = 8'h01;
  localparam logic [7:0] RT_DATA  = 8'h02;
  localparam logic [7:0] RT_LDATA = 8'h10;
  localparam logic [7:0] RT_LINSN = 8'h11;

  localparam logic [31:0] UNIF_BASE   = 32'h0000_0000;
  localparam logic [31:0] INSN_BASE   = 32'h0100_0000;
  localparam logic [31:0] DATA_BASE   = 32'h0200_0000;
  localparam logic [31:0] IO_STRIDE   = 32'h0001_0000;
  localparam logic [31:0] IO_OFFSET   = 32'h0000_C000;
  localparam logic [31:0] IO_NIB_SPAN = 32'h0000_1000;
  localparam logic [31:0] TEST_SPAN   = 32'h0000_0800;

  localparam logic [15:0] IMAP_ADDR  = 16'hFF00;
  localparam logic [15:0] DMAP_ADDR  = 16'hFF08;
  localparam logic [15:0] ALIAS_ADDR = 16'hFF04;
  localparam int          ALIAS_WIN  = 2;
  localparam int          IO_WIN     = 3;

  // One candidate translation: room is the byte count left before a boundary
  typedef struct packed {
    logic        fault;
    logic [31:0] addr;
    logic [31:0] room;
  } hit_t;

  function automatic logic [31:0] clamp_len(input logic [31:0] want,
                                            input logic [31:0] room);
    return (want > room) ? room : want;
  endfunction

  function automatic space_e space_of(input logic [15:0] map);
    return space_e'(map[13:12]);
  endfunction

  // Nibble index 0 is the most significant nibble of the map value
  function automatic logic [3:0] io_nibble(input logic [15:0] map,
                                           input logic [31:0] woff);
    logic [1:0] sel;
    sel = 2'((woff / IO_NIB_SPAN) % 4);
    return 4'(map >> (12 - 4 * sel));
  endfunction

endpackage

// File: rtl/awx_map_file.sv
`timescale 1ns/1ps
module awx_map_file
  import awx_pkg::*;
#(
  parameter int DWIN = 4,
  parameter int IWIN = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [15:0]          cfg_addr,
  input  logic [15:0]          cfg_wdata,
  output logic [DWIN*16-1:0]   dmap_flat,
  output logic [IWIN*16-1:0]   imap_flat
);

  for (genvar d = 0; d < DWIN; d++) begin : g_dmap
    logic        hit;
    logic [15:0] r;
    assign hit = cfg_we && ((cfg_addr == DMAP_ADDR + 16'(2 * d)) ||
                            ((d == ALIAS_WIN) && (cfg_addr == ALIAS_ADDR)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   r <= '0;
      else if (hit) r <= cfg_wdata;
    end
    assign dmap_flat[d*16 +: 16] = r;
  end

  for (genvar i = 0; i < IWIN; i++) begin : g_imap
    logic        hit;
    logic [15:0] r;
    assign hit = cfg_we && (cfg_addr == IMAP_ADDR + 16'(2 * i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   r <= '0;
      else if (hit) r <= cfg_wdata;
    end
    assign imap_flat[i*16 +: 16] = r;
  end

endmodule

// File: rtl/awx_data_path.sv
`timescale 1ns/1ps
module awx_data_path
  import awx_pkg::*;
#(
  parameter int DWIN = 4,
  parameter int DBLK = 16384
) (
  input  logic [23:0]        off,
  input  logic [DWIN*16-1:0] dmap_flat,
  output hit_t               res,
  output logic               io_hit
);

  localparam int          BLK_W = $clog2(DBLK);
  localparam logic [31:0] BLK   = 32'(DBLK);
  localparam logic [31:0] SPAN  = 32'(DWIN * DBLK);

  logic [31:0] off_w, win, woff;
  logic [15:0] map;
  logic [9:0]  seg;
  logic        in_range;

  assign off_w    = {8'h00, off};
  assign win      = off_w >> BLK_W;
  assign woff     = off_w & (BLK - 32'd1);
  assign in_range = off_w < SPAN;
  assign seg      = map[9:0];
  assign io_hit   = in_range && (win == 32'(IO_WIN));

  always_comb begin
    map = '0;
    for (int i = 0; i < DWIN; i++)
      if (win == 32'(i)) map = dmap_flat[i*16 +: 16];
  end

  always_comb begin
    res.fault = 1'b0;
    res.addr  = '0;
    res.room  = BLK - woff;
    if (!in_range) begin
      res.fault = 1'b1;
    end else if (io_hit) begin
      res.addr = DATA_BASE + ({28'h0, io_nibble(map, woff)} * IO_STRIDE)
               + IO_OFFSET + woff;
    end else begin
      unique case (space_of(map))
        SP_UNIF: res.addr = UNIF_BASE + {22'h0, seg} * BLK + woff;
        SP_INSN: res.addr = INSN_BASE + {22'h0, seg} * BLK + woff;
        SP_DATA: res.addr = DATA_BASE + ({22'h0, seg} << 16) + win * BLK + woff;
        SP_ALT:  res.fault = 1'b1;
      endcase
    end
    if (res.fault) begin
      res.addr = '0;
      res.room = '0;
    end
  end

endmodule

// File: rtl/awx_insn_path.sv
`timescale 1ns/1ps
module awx_insn_path
  import awx_pkg::*;
#(
  parameter int IWIN = 2,
  parameter int IBLK = 131072
) (
  input  logic [23:0]        off,
  input  logic [IWIN*16-1:0] imap_flat,
  output hit_t               res,
  output logic               test_hit
);

  localparam int          BLK_W = $clog2(IBLK);
  localparam logic [31:0] BLK   = 32'(IBLK);
  localparam logic [31:0] SPAN  = 32'(IWIN * IBLK);

  logic [31:0] off_w, win, woff, wrap;
  logic [15:0] map;
  logic [6:0]  seg;
  logic        in_range;
  logic        unused_map_bits;

  assign off_w           = {8'h00, off};
  assign win             = off_w >> BLK_W;
  assign woff            = off_w & (BLK - 32'd1);
  assign wrap            = woff % TEST_SPAN;
  assign in_range        = off_w < SPAN;
  assign seg             = map[6:0];
  assign test_hit        = in_range && (space_of(map) == SP_ALT);
  assign unused_map_bits = ^{map[15:14], map[11:7]};

  always_comb begin
    map = '0;
    for (int i = 0; i < IWIN; i++)
      if (win == 32'(i)) map = imap_flat[i*16 +: 16];
  end

  always_comb begin
    res.fault = 1'b0;
    res.addr  = '0;
    res.room  = BLK - woff;
    if (!in_range) begin
      res.fault = 1'b1;
    end else begin
      unique case (space_of(map))
        SP_UNIF: res.addr = UNIF_BASE + ({25'h0, seg} << 17) + woff;
        SP_INSN: res.addr = INSN_BASE + BLK * win + woff;
        SP_DATA: res.fault = 1'b1;
        SP_ALT: begin
          res.addr = INSN_BASE + wrap;
          res.room = clamp_len(BLK - woff, TEST_SPAN - wrap);
        end
      endcase
    end
    if (res.fault) begin
      res.addr = '0;
      res.room = '0;
    end
  end

endmodule

// File: rtl/addr_window_xlat.sv
`timescale 1ns/1ps
module addr_window_xlat
  import awx_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int DWIN  = 4,
  parameter int IWIN  = 2,
  parameter int DBLK  = 16384,
  parameter int IBLK  = 131072,
  parameter int SEG   = 65536
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [15:0]      cfg_addr,
  input  logic [15:0]      cfg_wdata,
  input  logic             req_valid,
  input  logic [31:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic             rsp_valid,
  output logic [31:0]      rsp_addr,
  output logic [LEN_W-1:0] rsp_len,
  output logic             rsp_fault
);

  localparam logic [31:0] SEG_W = 32'(SEG);

  logic [DWIN*16-1:0] dmap_flat;
  logic [IWIN*16-1:0] imap_flat;
  logic [7:0]         route;
  logic [23:0]        off;
  hit_t               dres, ires, sel;
  logic               io_hit, test_hit;
  logic [31:0]        grant;

  assign route = req_addr[31:24];
  assign off   = req_addr[23:0];

  awx_map_file #(.DWIN(DWIN), .IWIN(IWIN)) u_maps (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .dmap_flat(dmap_flat), .imap_flat(imap_flat)
  );

  awx_data_path #(.DWIN(DWIN), .DBLK(DBLK)) u_dpath (
    .off(off), .dmap_flat(dmap_flat), .res(dres), .io_hit(io_hit)
  );

  awx_insn_path #(.IWIN(IWIN), .IBLK(IBLK)) u_ipath (
    .off(off), .imap_flat(imap_flat), .res(ires), .test_hit(test_hit)
  );

  always_comb begin
    sel.fault = 1'b1;
    sel.addr  = '0;
    sel.room  = '0;
    case (route)
      RT_UNIF, RT_INSN, RT_DATA: begin
        sel.fault = 1'b0;
        sel.addr  = req_addr;
        sel.room  = SEG_W - ({8'h00, off} % SEG_W);
      end
      RT_LDATA: sel = dres;
      RT_LINSN: sel = ires;
      default:  ;
    endcase
  end

  assign grant = sel.fault ? 32'd0 : clamp_len(32'(req_len), sel.room);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_len   <= '0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_addr  <= sel.fault ? 32'd0 : sel.addr;
        rsp_len   <= grant[LEN_W-1:0];
        rsp_fault <= sel.fault;
      end
    end
  end

endmodule

// File: rtl/awx_checker.sv
`timescale 1ns/1ps
module awx_checker #(
  parameter int LEN_W = 16,
  parameter int DWIN  = 4,
  parameter int IWIN  = 2,
  parameter int DBLK  = 16384,
  parameter int IBLK  = 131072,
  parameter int SEG   = 65536
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [31:0]      req_addr,
  input logic [LEN_W-1:0] req_len,
  input logic             rsp_valid,
  input logic [31:0]      rsp_addr,
  input logic [LEN_W-1:0] rsp_len,
  input logic             rsp_fault,
  input logic             io_hit,
  input logic             test_hit
);

  localparam logic [31:0] SEG_W  = 32'(SEG);
  localparam logic [31:0] DSPAN  = 32'(DWIN * DBLK);
  localparam logic [31:0] ISPAN  = 32'(IWIN * IBLK);

  logic [7:0]  rt;
  logic [31:0] off_w;
  logic        rt_known;
  assign rt       = req_addr[31:24];
  assign off_w    = {8'h00, req_addr[23:0]};
  assign rt_known = (rt <= 8'h02) || (rt == 8'h10) || (rt == 8'h11);

  a_r12_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r12_no_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r12_fault_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_len == '0 && rsp_addr == 32'd0));
  a_r1_bad_route_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rt_known) |=> rsp_fault);
  a_r1_phys_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rt <= 8'h02) |=> (!rsp_fault && rsp_addr == $past(req_addr)));
  a_r2_seg_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rt <= 8'h02) |=> ((rsp_addr % SEG_W) + 32'(rsp_len) <= SEG_W));
  a_r3_data_range: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rt == 8'h10 && off_w >= DSPAN) |=> rsp_fault);
  a_r9_insn_range: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rt == 8'h11 && off_w >= ISPAN) |=> rsp_fault);
  a_r10_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_len <= $past(req_len)));
  a_r6_io_never_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rt == 8'h10 && io_hit) |=> (!rsp_fault && rsp_addr[31:24] == 8'h02));
  a_r8_test_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rt == 8'h11 && test_hit) |=>
      (!rsp_fault && rsp_addr[31:11] == 21'h2000 &&
       ({21'h0, rsp_addr[10:0]} + 32'(rsp_len) <= 32'h800)));

endmodule

bind addr_window_xlat awx_checker #(
  .LEN_W(LEN_W), .DWIN(DWIN), .IWIN(IWIN), .DBLK(DBLK), .IBLK(IBLK), .SEG(SEG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_len(req_len), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
  .rsp_len(rsp_len), .rsp_fault(rsp_fault), .io_hit(io_hit), .test_hit(test_hit)
);

// File: tb/tb_addr_window_xlat.sv
`timescale 1ns/1ps
module tb_addr_window_xlat;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic        rsp_valid;
  logic [31:0] rsp_addr;
  logic [15:0] rsp_len;
  logic        rsp_fault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] addr;
    logic [15:0] len;
    logic        fault;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  addr_window_xlat dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_len(rsp_len), .rsp_fault(rsp_fault)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic push(input logic [31:0] ea, input logic [15:0] el,
                      input logic ef, input string tag);
    exp_t e;
    e.addr = ea; e.len = el; e.fault = ef; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic send(input logic [31:0] a, input logic [15:0] l,
                      input logic [31:0] ea, input logic [15:0] el,
                      input logic ef, input string tag);
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b1; req_addr = a; req_len = l;
    push(ea, el, ef, tag);
  endtask

  task automatic send_wr(input logic [31:0] a, input logic [15:0] l,
                         input logic [15:0] wa, input logic [15:0] wd,
                         input logic [31:0] ea, input logic [15:0] el,
                         input string tag);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = wa; cfg_wdata = wd;
    req_valid = 1'b1; req_addr = a; req_len = l;
    push(ea, el, 1'b0, tag);
  endtask

  task automatic wmap(input logic [15:0] wa, input logic [15:0] wd);
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b1; cfg_addr = wa; cfg_wdata = wd;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
  endtask

  // Monitor: responses are registered, so sample them at the falling edge
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R12 unexpected response: got addr=%h len=%0d fault=%b, expected none",
                 rsp_addr, rsp_len, rsp_fault);
      end else begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (rsp_addr !== e.addr || rsp_len !== e.len || rsp_fault !== e.fault) begin
          errors++;
          $display("FAIL %s: got addr=%h len=%0d fault=%b, expected addr=%h len=%0d fault=%b",
                   e.tag, rsp_addr, rsp_len, rsp_fault, e.addr, e.len, e.fault);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R12 watchdog: got run still active, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R12 reset: got rsp_valid=%b, expected 0", rsp_valid);
    end
    rst_n = 1'b1;
    idle();

    // R11 reset values are zero: data window 0 code 00 seg 0, instruction window 0 likewise
    send(32'h1000_0100, 16'd4, 32'h0000_0100, 16'd4, 1'b0, "R11 reset data map");
    send(32'h1100_0010, 16'd4, 32'h0000_0010, 16'd4, 1'b0, "R11 reset insn map");
    // R3 / R10 last byte of the data space: I/O window, nibble 0 of zero map
    send(32'h1000_FFFF, 16'd4, 32'h0200_FFFF, 16'd1, 1'b0, "R3 R10 data space top");

    // R1 physical routes pass through, unknown routes fault
    send(32'h0012_3456, 16'd8, 32'h0012_3456, 16'd8, 1'b0, "R1 unified");
    send(32'h0100_0010, 16'd2, 32'h0100_0010, 16'd2, 1'b0, "R1 insn");
    send(32'h02AB_CDEF, 16'd1, 32'h02AB_CDEF, 16'd1, 1'b0, "R1 data");
    send(32'h0500_0000, 16'd4, 32'h0, 16'd0, 1'b1, "R1 route 05");
    send(32'h1200_0000, 16'd4, 32'h0, 16'd0, 1'b1, "R1 route 12");
    send(32'hFF00_0000, 16'd4, 32'h0, 16'd0, 1'b1, "R1 route FF");

    // R2 segment clamp
    send(32'h0001_FFFE, 16'd16, 32'h0001_FFFE, 16'd2, 1'b0, "R2 clamp unified");
    send(32'h02FF_FFF0, 16'h20, 32'h02FF_FFF0, 16'h10, 1'b0, "R2 clamp data");
    send(32'h0003_0000, 16'd0, 32'h0003_0000, 16'd0, 1'b0, "R2 zero length");
    send(32'h0100_8000, 16'hFFFF, 32'h0100_8000, 16'h8000, 1'b0, "R2 long request");

    // R3 out of data range
    send(32'h1001_0000, 16'd4, 32'h0, 16'd0, 1'b1, "R3 offset 0x10000");
    send(32'h10FF_FFFF, 16'd4, 32'h0, 16'd0, 1'b1, "R3 offset max");

    // R4 data space codes (R11 addressing, alias at FF04)
    wmap(16'hFF0A, 16'h0005);
    send(32'h1000_4010, 16'd4, 32'h0001_4010, 16'd4, 1'b0, "R4 code00 win1");
    wmap(16'hFF08, 16'h1003);
    send(32'h1000_0020, 16'd4, 32'h0100_C020, 16'd4, 1'b0, "R4 code01 win0");
    wmap(16'hFF04, 16'h2002);
    send(32'h1000_8040, 16'd4, 32'h0202_8040, 16'd4, 1'b0, "R4 R11 code10 alias win2");

    // R11 write to an unused address changes nothing
    wmap(16'hFF06, 16'hFFFF);
    send(32'h1000_0020, 16'd4, 32'h0100_C020, 16'd4, 1'b0, "R11 ignored write win0");
    send(32'h1000_8040, 16'd4, 32'h0202_8040, 16'd4, 1'b0, "R11 ignored write win2");
    send(32'h1100_0010, 16'd4, 32'h0000_0010, 16'd4, 1'b0, "R11 ignored write imap0");
    send(32'h1000_4010, 16'd4, 32'h0001_4010, 16'd4, 1'b0, "R11 ignored write win1");

    // R4 field masking: bits outside code and segment are ignored
    wmap(16'hFF08, 16'hC3FF);
    send(32'h1000_0000, 16'd2, 32'h00FF_C000, 16'd2, 1'b0, "R4 segment mask");

    // R5 reserved data code
    wmap(16'hFF0A, 16'h3000);
    send(32'h1000_4000, 16'd4, 32'h0, 16'd0, 1'b1, "R5 code11 data");

    // R11 write seen next cycle, not in the same cycle
    wmap(16'hFF0A, 16'h0005);
    send_wr(32'h1000_4000, 16'd4, 16'hFF0A, 16'h0006, 32'h0001_4000, 16'd4, "R11 same-cycle old map");
    send(32'h1000_4000, 16'd4, 32'h0001_8000, 16'd4, 1'b0, "R11 next-cycle new map");
    // R10 data window end clamp
    send(32'h1000_7FFC, 16'd8, 32'h0001_BFFC, 16'd4, 1'b0, "R10 data window clamp");

    // R6 I/O window nibbles
    wmap(16'hFF0E, 16'h1234);
    send(32'h1000_C000, 16'd4, 32'h0201_C000, 16'd4, 1'b0, "R6 nibble 0");
    send(32'h1000_D100, 16'd4, 32'h0202_D100, 16'd4, 1'b0, "R6 nibble 1");
    send(32'h1000_E004, 16'd4, 32'h0203_E004, 16'd4, 1'b0, "R6 nibble 2");
    send(32'h1000_FFF0, 16'h40, 32'h0204_FFF0, 16'h10, 1'b0, "R6 R10 nibble 3 clamp");
    wmap(16'hFF0E, 16'h3000);
    send(32'h1000_C000, 16'd4, 32'h0203_C000, 16'd4, 1'b0, "R6 code ignored");

    // R7 instruction space codes
    wmap(16'hFF00, 16'h0003);
    send(32'h1100_0100, 16'd4, 32'h0006_0100, 16'd4, 1'b0, "R7 code00 win0");
    wmap(16'hFF02, 16'h1000);
    send(32'h1102_0010, 16'd4, 32'h0102_0010, 16'd4, 1'b0, "R7 code01 win1");
    wmap(16'hFF00, 16'h00FF);
    send(32'h1100_0000, 16'd4, 32'h00FE_0000, 16'd4, 1'b0, "R7 segment mask");
    send(32'h1103_FFF8, 16'h20, 32'h0103_FFF8, 16'd8, 1'b0, "R10 insn window clamp");

    // R8 reserved and test codes
    wmap(16'hFF02, 16'h2000);
    send(32'h1102_0000, 16'd4, 32'h0, 16'd0, 1'b1, "R8 code10 insn");
    wmap(16'hFF00, 16'h3000);
    send(32'h1100_1804, 16'd8, 32'h0100_0004, 16'd8, 1'b0, "R8 test wrap");
    send(32'h1100_07FC, 16'd16, 32'h0100_07FC, 16'd4, 1'b0, "R8 test clamp");

    // R9 out of instruction range
    send(32'h1104_0000, 16'd4, 32'h0, 16'd0, 1'b1, "R9 offset 0x40000");
    send(32'h11FF_FFFF, 16'd4, 32'h0, 16'd0, 1'b1, "R9 offset max");

    // R12 idle stretch: no responses expected
    repeat (5) idle();
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R12 missing responses: got %0d outstanding, expected 0", sb.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule